// File: doc/BRIEF.md
# USB Power Delivery BMC Packet Transmitter

This block turns one USB Power Delivery message request into a complete packet on a single CC wire. A request pulse latches the message type, message ID, data-object count and up to seven 32-bit data objects. The block then drives a bit-alternating preamble, the start-of-packet ordered set, the 16-bit header, the data objects, a CRC-32 and the end-of-packet symbol onto one line output, with an output enable for the analog driver. Every field after the preamble goes through 4b5b symbol coding, and every bit is line coded with biphase mark coding. A clock divider sets the half-bit period. A one-cycle `done` pulse marks the release of the line.

The framer state machine steps through these states: IDLE → PREAMBLE → SOP → HEADER → DATA → CRC → EOP → TAIL → IDLE. IDLE→PREAMBLE fires on an accepted `start`. PREAMBLE→SOP fires at the end of bit 63. SOP→HEADER fires after the fourth sync symbol. HEADER→DATA fires after the fourth header symbol when the count is nonzero. HEADER→CRC fires instead when the count is zero. DATA→CRC fires after the eighth symbol of the last object. CRC→EOP fires after the eighth CRC symbol. EOP→TAIL fires after the fifth EOP bit. TAIL→IDLE fires when the final half-bit ends. A separate line coder owns the half-bit timer, the line level and the enable. A nibble-wide CRC engine updates once per header or data symbol.

Top module: `pd_bmc_tx`

## Requirements
- R1: While reset is held and after it is released, `cc_oe`, `busy` and `done` are 0 until a request arrives.
- R2: The packet opens with 64 uncoded bits alternating 1,0,1,0..., with a 1 first.
- R3: After the preamble, four 5-bit sync symbols follow: 0x18, 0x18, 0x18, 0x11. Every 5-bit symbol is sent bit 0 first.
- R4: Each nibble maps to a 5-bit symbol. The symbols for nibbles 0..F are 0x1E, 0x09, 0x14, 0x15, 0x0A, 0x0B, 0x0E, 0x0F, 0x12, 0x13, 0x16, 0x17, 0x1A, 0x1B, 0x1C, 0x1D. Multi-nibble fields are sent least significant nibble first.
- R5: The header field layout is as follows. Bits [4:0] hold the message type. Bits [8:5] are 0. Bits [11:9] hold the message ID. Bits [14:12] hold the object count. Bit 15 is 0. The header is sent as 4 symbols. All request fields are latched at `start`.
- R6: Data objects 0 to count-1 follow the header in order, 8 symbols each. Object i is `obj_data[32*i+31:32*i]`. A count of 0 sends no objects, which gives a control message.
- R7: After the last object (or the header), 8 symbols carry the CRC-32. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF, covers the header and then the objects with each field taken bit 0 first, and is complemented at the end.
- R8: The symbol 0x0D ends the packet. One further half-bit follows, after which `cc_oe` drops.
- R9: The line toggles at every bit boundary, including the boundary after the last EOP bit. It toggles again mid-bit for a 1. Every half-bit lasts exactly `HALF_BIT_CLKS` clocks, so `cc_oe` stays high for (2·bits+1)·`HALF_BIT_CLKS` clocks.
- R10: `busy` and `cc_oe` rise in the cycle after an accepted `start`. Both fall together with a one-cycle `done` pulse. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| msg_type | input | 5 | Message type code for the header |
| msg_id | input | 3 | Message ID for the header |
| obj_count | input | 3 | Number of data objects (0 = control message) |
| obj_data | input | MAX_OBJ*32 | Data objects, object i at bits [32i+31:32i] |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse when the line is released |
| cc_out | output | 1 | BMC-coded line level |
| cc_oe | output | 1 | Line driver enable |

## Verification
Most internal faults become visible on `cc_out` within one bit period. A wrong symbol counter, a bad table entry or a missed CRC update changes the decoded bit stream in the very symbol it corrupts, or at the latest in the CRC field that ends the packet. A stuck or misloaded state shifts every later field and changes how long `cc_oe` stays high, and the count of high cycles is checked against the exact expected length. A timer fault moves a line transition off its half-bit grid at the next edge. The same fault also changes the total enable width.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_SOP, ST_HDR, ST_DATA, ST_CRC, ST_EOP, ST_TAIL
    } tx_state_t;

    localparam int PRE_BITS = 64;
    localparam int SYM_BITS = 5;
    localparam int OBJ_W    = 32;
    localparam int OBJ_NIBS = OBJ_W / 4;
    localparam int HDR_NIBS = 4;
    localparam int CRC_NIBS = 8;
    localparam int SOP_SYMS = 4;

    localparam logic [4:0]  SYNC1_SYM  = 5'h18;
    localparam logic [4:0]  SYNC2_SYM  = 5'h11;
    localparam logic [4:0]  EOP_SYM    = 5'h0D;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

    function automatic logic [4:0] enc4b5b(input logic [3:0] nib);
        logic [4:0] s;
        unique case (nib)
            4'h0: s = 5'h1E;
            4'h1: s = 5'h09;
            4'h2: s = 5'h14;
            4'h3: s = 5'h15;
            4'h4: s = 5'h0A;
            4'h5: s = 5'h0B;
            4'h6: s = 5'h0E;
            4'h7: s = 5'h0F;
            4'h8: s = 5'h12;
            4'h9: s = 5'h13;
            4'hA: s = 5'h16;
            4'hB: s = 5'h17;
            4'hC: s = 5'h1A;
            4'hD: s = 5'h1B;
            4'hE: s = 5'h1C;
            default: s = 5'h1D;
        endcase
        return s;
    endfunction

    function automatic logic [31:0] crc_nib_step(input logic [31:0] c, input logic [3:0] nib);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            r = (r >> 1) ^ ((r[0] ^ nib[i]) ? CRC_POLY_R : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/pd_crc32_nib.sv
module pd_crc32_nib
    import pd_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [3:0]  nib,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (clr) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc_nib_step(crc_q, nib);
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/pd_bmc_line.sv
module pd_bmc_line #(
    parameter int HALF_BIT_CLKS = 330
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic stop,
    input  logic bit_in,
    output logic half_end,
    output logic bit_end,
    output logic cc_out,
    output logic cc_oe
);
    localparam int CW = (HALF_BIT_CLKS > 1) ? $clog2(HALF_BIT_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_BIT_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          line_q;
    logic          oe_q;

    assign half_end = oe_q && (cnt_q == CNT_LAST);
    assign bit_end  = half_end && phase_q;
    assign cc_out   = line_q;
    assign cc_oe    = oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            line_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (go) begin
            oe_q    <= 1'b1;
            line_q  <= ~line_q;
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (stop) begin
            oe_q    <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (oe_q) begin
            if (half_end) begin
                cnt_q <= '0;
                if (!phase_q) begin
                    phase_q <= 1'b1;
                    if (bit_in) line_q <= ~line_q;
                end else begin
                    phase_q <= 1'b0;
                    line_q  <= ~line_q;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pd_tx_framer.sv
module pd_tx_framer
    import pd_tx_pkg::*;
#(
    parameter int MAX_OBJ = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [4:0]               msg_type,
    input  logic [2:0]               msg_id,
    input  logic [2:0]               obj_count,
    input  logic [MAX_OBJ*OBJ_W-1:0] obj_data,
    input  logic                     half_end,
    input  logic                     bit_end,
    input  logic [31:0]              crc_fcs,
    output logic                     bmc_go,
    output logic                     bmc_stop,
    output logic                     tx_bit,
    output logic                     crc_clr,
    output logic                     crc_upd,
    output logic [3:0]               crc_nib,
    output logic                     busy,
    output logic                     done
);
    localparam logic [2:0] CNT_MAX = 3'(MAX_OBJ);

    tx_state_t        state_q, nxt_state;
    logic [5:0]       bit_cnt_q, nxt_bit;
    logic [2:0]       sym_cnt_q, nxt_sym;
    logic [2:0]       obj_idx_q, nxt_obj;
    logic [2:0]       cnt_q;
    logic [15:0]      hdr_q;
    logic [OBJ_W-1:0] obj_q [MAX_OBJ];
    logic             done_q;

    logic [3:0] cur_nib;
    logic [4:0] cur_sym;
    logic       sym_last;
    logic [2:0] cnt_clamped;

    assign cnt_clamped = (obj_count > CNT_MAX) ? CNT_MAX : obj_count;
    assign sym_last    = (bit_cnt_q == 6'(SYM_BITS - 1));

    // Current nibble for coded fields
    always_comb begin
        cur_nib = 4'h0;
        unique case (state_q)
            ST_HDR:  cur_nib = hdr_q[{sym_cnt_q[1:0], 2'b00} +: 4];
            ST_DATA: cur_nib = obj_q[obj_idx_q][{sym_cnt_q, 2'b00} +: 4];
            ST_CRC:  cur_nib = crc_fcs[{sym_cnt_q, 2'b00} +: 4];
            default: cur_nib = 4'h0;
        endcase
    end

    // Current symbol on the wire
    always_comb begin
        cur_sym = 5'h00;
        unique case (state_q)
            ST_SOP:                  cur_sym = (sym_cnt_q == 3'(SOP_SYMS - 1)) ? SYNC2_SYM : SYNC1_SYM;
            ST_HDR, ST_DATA, ST_CRC: cur_sym = enc4b5b(cur_nib);
            ST_EOP:                  cur_sym = EOP_SYM;
            default:                 cur_sym = 5'h00;
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt_state = state_q;
        nxt_bit   = bit_cnt_q;
        nxt_sym   = sym_cnt_q;
        nxt_obj   = obj_idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    nxt_state = ST_PRE;
                    nxt_bit   = '0;
                    nxt_sym   = '0;
                    nxt_obj   = '0;
                end
            end
            ST_PRE: begin
                if (bit_end) begin
                    if (bit_cnt_q == 6'(PRE_BITS - 1)) begin
                        nxt_state = ST_SOP;
                        nxt_bit   = '0;
                    end else begin
                        nxt_bit = bit_cnt_q + 1'b1;
                    end
                end
            end
            ST_SOP, ST_HDR, ST_DATA, ST_CRC, ST_EOP: begin
                if (bit_end) begin
                    if (!sym_last) begin
                        nxt_bit = bit_cnt_q + 1'b1;
                    end else begin
                        nxt_bit = '0;
                        nxt_sym = sym_cnt_q + 1'b1;
                        if (state_q == ST_SOP && sym_cnt_q == 3'(SOP_SYMS - 1)) begin
                            nxt_state = ST_HDR;
                            nxt_sym   = '0;
                        end else if (state_q == ST_HDR && sym_cnt_q == 3'(HDR_NIBS - 1)) begin
                            nxt_state = (cnt_q == 3'd0) ? ST_CRC : ST_DATA;
                            nxt_sym   = '0;
                            nxt_obj   = '0;
                        end else if (state_q == ST_DATA && sym_cnt_q == 3'(OBJ_NIBS - 1)) begin
                            nxt_sym = '0;
                            if (obj_idx_q == cnt_q - 1'b1) begin
                                nxt_state = ST_CRC;
                            end else begin
                                nxt_obj = obj_idx_q + 1'b1;
                            end
                        end else if (state_q == ST_CRC && sym_cnt_q == 3'(CRC_NIBS - 1)) begin
                            nxt_state = ST_EOP;
                            nxt_sym   = '0;
                        end else if (state_q == ST_EOP) begin
                            nxt_state = ST_TAIL;
                            nxt_sym   = '0;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (half_end) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            sym_cnt_q <= '0;
            obj_idx_q <= '0;
            cnt_q     <= '0;
            hdr_q     <= '0;
            done_q    <= 1'b0;
            for (int i = 0; i < MAX_OBJ; i++) obj_q[i] <= '0;
        end else begin
            state_q   <= nxt_state;
            bit_cnt_q <= nxt_bit;
            sym_cnt_q <= nxt_sym;
            obj_idx_q <= nxt_obj;
            done_q    <= (state_q == ST_TAIL) && half_end;
            if (state_q == ST_IDLE && start) begin
                cnt_q <= cnt_clamped;
                hdr_q <= {1'b0, cnt_clamped, msg_id, 4'b0000, msg_type};
                for (int i = 0; i < MAX_OBJ; i++) obj_q[i] <= obj_data[i*OBJ_W +: OBJ_W];
            end
        end
    end

    // Outputs
    always_comb begin
        bmc_go   = (state_q == ST_IDLE) && start;
        bmc_stop = (state_q == ST_TAIL) && half_end;
        crc_clr  = bmc_go;
        crc_upd  = bit_end && sym_last && ((state_q == ST_HDR) || (state_q == ST_DATA));
        crc_nib  = cur_nib;
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        unique case (state_q)
            ST_PRE:                                  tx_bit = ~bit_cnt_q[0];
            ST_SOP, ST_HDR, ST_DATA, ST_CRC, ST_EOP: tx_bit = cur_sym[bit_cnt_q[2:0]];
            default:                                 tx_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pd_bmc_tx.sv
module pd_bmc_tx
    import pd_tx_pkg::*;
#(
    parameter int MAX_OBJ       = 7,
    parameter int HALF_BIT_CLKS = 330
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [4:0]               msg_type,
    input  logic [2:0]               msg_id,
    input  logic [2:0]               obj_count,
    input  logic [MAX_OBJ*OBJ_W-1:0] obj_data,
    output logic                     busy,
    output logic                     done,
    output logic                     cc_out,
    output logic                     cc_oe
);
    logic        half_end;
    logic        bit_end;
    logic        bmc_go;
    logic        bmc_stop;
    logic        tx_bit;
    logic        crc_clr;
    logic        crc_upd;
    logic [3:0]  crc_nib;
    logic [31:0] crc_fcs;

    pd_tx_framer #(.MAX_OBJ(MAX_OBJ)) u_framer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .msg_type(msg_type), .msg_id(msg_id), .obj_count(obj_count), .obj_data(obj_data),
        .half_end(half_end), .bit_end(bit_end), .crc_fcs(crc_fcs),
        .bmc_go(bmc_go), .bmc_stop(bmc_stop), .tx_bit(tx_bit),
        .crc_clr(crc_clr), .crc_upd(crc_upd), .crc_nib(crc_nib),
        .busy(busy), .done(done)
    );

    pd_crc32_nib u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .nib(crc_nib), .fcs(crc_fcs)
    );

    pd_bmc_line #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) u_line (
        .clk(clk), .rst_n(rst_n), .go(bmc_go), .stop(bmc_stop), .bit_in(tx_bit),
        .half_end(half_end), .bit_end(bit_end), .cc_out(cc_out), .cc_oe(cc_oe)
    );
endmodule

// File: rtl/pd_bmc_tx_chk.sv
module pd_bmc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic cc_out,
    input logic cc_oe,
    input logic half_end
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_oe) |-> done);

    // R10
    busy_oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == cc_oe);

    // R9
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_oe && $past(cc_oe) && !$past(half_end)) |-> $stable(cc_out));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind pd_bmc_tx pd_bmc_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cc_out(cc_out), .cc_oe(cc_oe), .half_end(half_end)
);

// File: tb/pd_bmc_tx_tb.sv
module pd_bmc_tx_tb;
    localparam int MAX_OBJ = 7;
    localparam int HB      = 4;
    localparam int DW      = MAX_OBJ * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    msg_type = '0;
    logic [2:0]    msg_id = '0;
    logic [2:0]    obj_count = '0;
    logic [DW-1:0] obj_data = '0;
    logic          busy, done, cc_out, cc_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    bit exp_b [0:511];
    int exp_n;
    bit halves [0:1023];
    int hn = 0;
    int oc = 0;

    always #2.5 clk = ~clk;

    pd_bmc_tx #(.MAX_OBJ(MAX_OBJ), .HALF_BIT_CLKS(HB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_type(msg_type), .msg_id(msg_id),
        .obj_count(obj_count), .obj_data(obj_data), .busy(busy), .done(done),
        .cc_out(cc_out), .cc_oe(cc_oe)
    );

    always @(negedge clk) begin
        if (cc_oe) begin
            if ((oc % HB) == HB / 2) begin
                if (hn < 1024) halves[hn] = cc_out;
                hn++;
            end
            oc++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [4:0] sym_of(input logic [3:0] n);
        logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                               5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        return t[n];
    endfunction

    function automatic logic [31:0] ref_crc(input logic [15:0] hdr, input int n, input logic [DW-1:0] d);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 16; i++) begin
            if (c[0] ^ hdr[i]) c = (c >> 1) ^ 32'hEDB88320; else c = c >> 1;
        end
        for (int i = 0; i < n * 32; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320; else c = c >> 1;
        end
        return ~c;
    endfunction

    task automatic push_sym(input logic [4:0] s);
        for (int i = 0; i < 5; i++) begin
            exp_b[exp_n] = s[i];
            exp_n++;
        end
    endtask

    task automatic push_field(input logic [31:0] v, input int nibs);
        for (int i = 0; i < nibs; i++) push_sym(sym_of(v[i*4 +: 4]));
    endtask

    task automatic build(input logic [4:0] t, input logic [2:0] id, input logic [2:0] n, input logic [DW-1:0] d);
        logic [15:0] hdr;
        hdr = {1'b0, n, id, 4'b0000, t};
        exp_n = 0;
        for (int i = 0; i < 64; i++) begin
            exp_b[exp_n] = (i % 2 == 0);
            exp_n++;
        end
        push_sym(5'h18); push_sym(5'h18); push_sym(5'h18); push_sym(5'h11);
        push_field({16'h0, hdr}, 4);
        for (int k = 0; k < int'(n); k++) push_field(d[k*32 +: 32], 8);
        push_field(ref_crc(hdr, int'(n), d), 8);
        push_sym(5'h0D);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cmp_region(input string req, input string what, input int lo, input int hi);
        int bad;
        bad = 0;
        for (int k = lo; k < hi; k++) begin
            if (2 * k + 1 >= hn || 2 * k + 1 >= 1024) bad++;
            else if ((halves[2*k] != halves[2*k+1]) != exp_b[k]) bad++;
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    task automatic run_pkt(input logic [4:0] t, input logic [2:0] id, input logic [2:0] n,
                           input logic [DW-1:0] d, input bit poke);
        int tog_bad;
        int p;
        build(t, id, n, d);
        @(negedge clk);
        hn = 0; oc = 0;
        start = 1'b1; msg_type = t; msg_id = id; obj_count = n; obj_data = d;
        @(negedge clk);
        start = 1'b0;
        check(busy && cc_oe, "R10", "busy/oe after start", {30'd0, busy, cc_oe}, 3);
        if (poke) begin
            repeat (50) @(negedge clk);
            start = 1'b1; msg_type = ~t; msg_id = ~id; obj_count = ~n; obj_data = ~d;
            @(negedge clk);
            start = 1'b0;
        end
        while (cc_oe) @(negedge clk);
        check(done && !busy, "R10", "done at release", {30'd0, done, busy}, 2);
        @(negedge clk);
        check(!done, "R10", "done one cycle", int'(done), 0);
        check(oc == (2 * exp_n + 1) * HB, "R9", "oe high cycles", oc, (2 * exp_n + 1) * HB);
        check(hn == 2 * exp_n + 1, "R8", "half-bit count", hn, 2 * exp_n + 1);
        tog_bad = 0;
        for (int k = 1; k <= exp_n && 2 * k < 1024; k++) begin
            if (halves[2*k] == halves[2*k-1]) tog_bad++;
        end
        check(tog_bad == 0, "R9", "boundary toggles", tog_bad, 0);
        p = 0;
        cmp_region("R2", "preamble", p, p + 64);              p += 64;
        cmp_region("R3", "sync symbols", p, p + 20);          p += 20;
        cmp_region("R5", "header (R4 coding)", p, p + 20);    p += 20;
        if (n != 0) cmp_region("R6", "data objects", p, p + 40 * int'(n));
        p += 40 * int'(n);
        cmp_region("R7", "crc", p, p + 40);                   p += 40;
        cmp_region("R8", "eop", p, p + 5);
        if (poke) begin
            repeat (30) @(negedge clk);
            check(!cc_oe && !busy, "R10", "start while busy ignored", int'(cc_oe), 0);
        end
    endtask

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        check(!cc_oe && !busy && !done, "R1", "idle in reset", {29'd0, cc_oe, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!cc_oe && !busy && !done, "R1", "idle after reset", {29'd0, cc_oe, busy, done}, 0);

        // Directed corners
        run_pkt(5'h03, 3'd0, 3'd0, '0, 1'b0);              // control message, R6 count 0
        run_pkt(5'h1F, 3'd7, 3'd7, {DW{1'b1}}, 1'b0);      // all-ones, max objects
        run_pkt(5'h00, 3'd2, 3'd7, '0, 1'b0);              // all-zero data
        for (int k = 0; k < MAX_OBJ; k++) d[k*32 +: 32] = 32'h76543210 + 32'h11111111 * k;
        run_pkt(5'h01, 3'd5, 3'd1, d, 1'b1);               // R10 ignored start mid-packet

        // Constrained random packets
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < MAX_OBJ; k++) d[k*32 +: 32] = $urandom();
            run_pkt(5'($urandom()), 3'($urandom()), 3'($urandom_range(0, MAX_OBJ)), d, (r == 3));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule